// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block sequences the operating mode of a CAN protocol controller. The CPU controls it with two plain level bits: a soft-reset bit and a sleep-request bit. The bus side supplies a sampled bus bit that is qualified by a bit-time strobe. The frame engine supplies three status flags: receive in progress, all transmit buffers empty, and bus-off. From these inputs the block selects one of four modes: soft reset, synchronizing, normal or sleep.

In soft reset the block holds the controller's status and interrupt registers at their reset values, and it enables CPU writes to the protected configuration registers. When soft reset is entered from any other mode, the block pulses an abort so that the frame engine drops any frame in flight. When the soft-reset bit is cleared, the block waits in the synchronizing mode for a run of recessive bits before it goes to normal mode. A node that is bus-off must see many such runs. In normal mode a sleep request is granted only while the bus is idle, and the sleep acknowledge output then serves the CPU as a handshake.

All pins are plain control and status levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every output is registered or decoded from the registered mode, and every mode change takes effect at the first clock edge that samples its cause.

Top module: `can_mode_seq`

## Requirements
- R1: While `srst_req` is 1 at a clock edge, `mode` reads 0 (soft reset) after that edge, from any mode. This holds even when a sleep request, a sleep wake-up or a resync completion occurs in the same cycle.
- R2: `abort_pulse` is 1 for exactly one cycle, in the first cycle of soft reset, when soft reset is entered from mode 1, 2 or 3. In every other cycle it is 0.
- R3: `cfg_wr_en` and `stat_hold` are 1 while `mode` is 0 and are 0 in every other mode. Protected configuration writes are therefore ignored outside soft reset.
- R4: Mode codes are 0 for soft reset, 1 for synchronizing, 2 for normal and 3 for sleep. During hard reset and after it, `mode` reads 0.
- R5: When `srst_req` is 0 in soft reset, the next mode is 1. With `bus_off` at 0, the mode becomes 2 at the edge that samples the 11th consecutive recessive bit in mode 1. A recessive bit is a cycle with `bit_tick`=1 and `bus_bit`=1. Cycles with `bit_tick`=0 are not counted.
- R6: A dominant sample in mode 1 (`bit_tick`=1, `bus_bit`=0) restarts the count of consecutive recessive bits from zero.
- R7: With `bus_off` at 1, mode 1 ends only after 128 completed runs of 11 recessive bits. A dominant sample discards only the partial run and keeps the runs already completed.
- R8: In mode 2, the mode becomes 3 at the next edge only if `sleep_req`=1, `rx_busy`=0 and `tx_empty`=1 all hold. `sleep_ack` is 1 exactly when the mode is 3.
- R9: In mode 3, the mode returns to 2 at the next edge when `sleep_req` is 0, or when a dominant sample is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| srst_req | input | 1 | CPU soft-reset control bit |
| sleep_req | input | 1 | CPU sleep-request control bit |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| bit_tick | input | 1 | One-cycle strobe marking a valid `bus_bit` sample |
| rx_busy | input | 1 | A frame is being received |
| tx_empty | input | 1 | All transmit buffers are empty |
| bus_off | input | 1 | Node is in the bus-off state |
| mode | output | 2 | Current mode: 0 soft reset, 1 sync, 2 normal, 3 sleep |
| sleep_ack | output | 1 | Sleep acknowledge handshake |
| abort_pulse | output | 1 | Abort any active frame |
| cfg_wr_en | output | 1 | Permits writes to protected configuration registers |
| stat_hold | output | 1 | Holds status and interrupt registers at reset values |

## Verification
The assertions assume that `bit_tick` qualifies `bus_bit` and that `bus_off` stays stable while a resynchronization is under way. They also assume that the flags may change in any cycle but are sampled only at the clock edge. The stimulus changes every input only on the falling clock edge. It keeps `bus_off` fixed through each synchronizing phase, and it raises `bit_tick` only on cycles whose bus level is meant to count as a sample.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MD_SRST  = 2'd0,
    MD_SYNC  = 2'd1,
    MD_NORM  = 2'd2,
    MD_SLEEP = 2'd3
  } mode_e;
endpackage

// File: rtl/can_run_counter.sv
module can_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic rec,
  output logic run_done
);
  localparam int W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [W-1:0] LAST = W'(RUN_LEN - 1);

  logic [W-1:0] cnt;

  assign run_done = !clr && tick && rec && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rec || run_done) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_run_tally.sv
module can_run_tally #(
  parameter int RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run_done,
  output logic tally_full
);
  localparam int W = (RUNS > 1) ? $clog2(RUNS) : 1;
  localparam logic [W-1:0] LAST = W'(RUNS - 1);

  logic [W-1:0] cnt;

  assign tally_full = run_done && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run_done) begin
      cnt <= tally_full ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst_req,
  input  logic  sleep_req,
  input  logic  dom_seen,
  input  logic  bus_idle,
  input  logic  sync_done,
  output mode_e mode_q,
  output logic  abort_q
);
  mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (srst_req) begin
      mode_d = MD_SRST;
    end else begin
      unique case (mode_q)
        MD_SRST:  mode_d = MD_SYNC;
        MD_SYNC:  if (sync_done) mode_d = MD_NORM;
        MD_NORM:  if (sleep_req && bus_idle) mode_d = MD_SLEEP;
        MD_SLEEP: if (!sleep_req || dom_seen) mode_d = MD_NORM;
        default:  mode_d = MD_SRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_SRST;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      abort_q <= srst_req && (mode_q != MD_SRST);
    end
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int RUNS    = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst_req,
  input  logic       sleep_req,
  input  logic       bus_bit,
  input  logic       bit_tick,
  input  logic       rx_busy,
  input  logic       tx_empty,
  input  logic       bus_off,
  output logic [1:0] mode,
  output logic       sleep_ack,
  output logic       abort_pulse,
  output logic       cfg_wr_en,
  output logic       stat_hold
);
  mode_e mode_q;
  logic  abort_q;
  logic  cnt_clr;
  logic  run_done;
  logic  tally_full;
  logic  sync_done;

  assign cnt_clr   = (mode_q != MD_SYNC);
  assign sync_done = run_done && (!bus_off || tally_full);

  can_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .tick     (bit_tick),
    .rec      (bus_bit),
    .run_done (run_done)
  );

  can_run_tally #(.RUNS(RUNS)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .run_done   (run_done),
    .tally_full (tally_full)
  );

  can_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_req  (srst_req),
    .sleep_req (sleep_req),
    .dom_seen  (bit_tick && !bus_bit),
    .bus_idle  (!rx_busy && tx_empty),
    .sync_done (sync_done),
    .mode_q    (mode_q),
    .abort_q   (abort_q)
  );

  assign mode        = mode_q;
  assign sleep_ack   = (mode_q == MD_SLEEP);
  assign abort_pulse = abort_q;
  assign cfg_wr_en   = (mode_q == MD_SRST);
  assign stat_hold   = (mode_q == MD_SRST);
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srst_req,
  input logic       sleep_req,
  input logic       bus_bit,
  input logic       bit_tick,
  input logic       rx_busy,
  input logic       tx_empty,
  input logic [1:0] mode,
  input logic       sleep_ack,
  input logic       abort_pulse,
  input logic       cfg_wr_en,
  input logic       stat_hold
);
  AST_SRST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> (mode == 2'd0)); // R1
  AST_ABORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (mode == 2'd0) && ($past(mode) != 2'd0)); // R2
  AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse); // R2
  AST_CFG_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> cfg_wr_en && stat_hold); // R3
  AST_CFG_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && !srst_req) |=> !cfg_wr_en); // R3
  AST_SRST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !srst_req) |=> (mode == 2'd1)); // R5
  AST_SYNC_NEEDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd1) |-> $past(bit_tick && bus_bit)); // R5
  AST_DOM_HOLDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && bit_tick && !bus_bit && !srst_req) |=> (mode == 2'd1)); // R6
  AST_SLEEP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> $past(sleep_req && !rx_busy && tx_empty)); // R8
  AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && sleep_req && !rx_busy && tx_empty && !srst_req) |=> sleep_ack); // R8
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !srst_req && (!sleep_req || (bit_tick && !bus_bit))) |=> (mode == 2'd2)); // R9
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .srst_req    (srst_req),
  .sleep_req   (sleep_req),
  .bus_bit     (bus_bit),
  .bit_tick    (bit_tick),
  .rx_busy     (rx_busy),
  .tx_empty    (tx_empty),
  .mode        (mode),
  .sleep_ack   (sleep_ack),
  .abort_pulse (abort_pulse),
  .cfg_wr_en   (cfg_wr_en),
  .stat_hold   (stat_hold)
);

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst_req = 1'b1, sleep_req = 1'b0, bus_bit = 1'b1, bit_tick = 1'b0;
  logic rx_busy = 1'b0, tx_empty = 1'b1, bus_off = 1'b0;
  logic [1:0] mode;
  logic sleep_ack, abort_pulse, cfg_wr_en, stat_hold;

  always #2.5 clk = ~clk;

  can_mode_seq i_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .sleep_req(sleep_req),
    .bus_bit(bus_bit), .bit_tick(bit_tick), .rx_busy(rx_busy),
    .tx_empty(tx_empty), .bus_off(bus_off), .mode(mode),
    .sleep_ack(sleep_ack), .abort_pulse(abort_pulse),
    .cfg_wr_en(cfg_wr_en), .stat_hold(stat_hold)
  );

  typedef struct {
    logic       chk;
    logic [1:0] md;
    logic       ab;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // next-cycle stimulus, applied by cyc() on the falling edge
  logic d_rst = 1'b0, d_srst = 1'b1, d_slp = 1'b0, d_bit = 1'b1, d_tick = 1'b0;
  logic d_rx = 1'b0, d_txe = 1'b1, d_boff = 1'b0;

  task automatic cyc(input logic chk, input logic [1:0] md, input logic ab, input string tag);
    exp_t it;
    @(negedge clk);
    rst_n = d_rst; srst_req = d_srst; sleep_req = d_slp; bus_bit = d_bit;
    bit_tick = d_tick; rx_busy = d_rx; tx_empty = d_txe; bus_off = d_boff;
    it.chk = chk; it.md = md; it.ab = ab; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rec_ticks(input int n, input logic [1:0] md, input string tag);
    d_tick = 1'b1; d_bit = 1'b1;
    for (int i = 0; i < n; i++) cyc(1'b0, md, 1'b0, tag);
  endtask

  // monitor: one expected item per driven cycle, sampled 1 ns after the rising edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk) begin
          n_cmp++;
          if (mode !== it.md || abort_pulse !== it.ab ||
              sleep_ack !== (it.md == 2'd3) ||
              cfg_wr_en !== (it.md == 2'd0) || stat_hold !== (it.md == 2'd0)) begin
            n_bad++;
            $display("FAIL %s: mode=%0d abort=%0b ack=%0b cfg=%0b hold=%0b expected mode=%0d abort=%0b",
                     it.tag, mode, abort_pulse, sleep_ack, cfg_wr_en, stat_hold, it.md, it.ab);
          end
        end
      end
    end
  end

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R4: hard reset state is soft reset
    cyc(1'b1, 2'd0, 1'b0, "R4 in hard reset");
    d_rst = 1'b1;
    cyc(1'b1, 2'd0, 1'b0, "R4 after reset, R3 cfg open");
    // R5: release, then 11 recessive samples
    d_srst = 1'b0; d_tick = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R5 enter sync, R3 protected write ignored");
    cyc(1'b1, 2'd1, 1'b0, "R5 idle tick not counted");
    rec_ticks(10, 2'd1, "R5 run");
    d_tick = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R5 ten recessive still sync");
    d_tick = 1'b1;
    cyc(1'b1, 2'd2, 1'b0, "R5 eleventh recessive -> normal");
    d_tick = 1'b0;
    cyc(1'b1, 2'd2, 1'b0, "R3 normal cfg closed");
    // R1/R2: soft reset from normal while a frame is active
    d_rx = 1'b1; d_txe = 1'b0; d_srst = 1'b1;
    cyc(1'b1, 2'd0, 1'b1, "R1 R2 srst from normal aborts");
    cyc(1'b1, 2'd0, 1'b0, "R2 abort single cycle");
    d_rx = 1'b0; d_txe = 1'b1; d_srst = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R2 no abort on exit");
    // R6: interrupted resync
    rec_ticks(6, 2'd1, "R6 partial");
    d_bit = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R6 dominant sample");
    rec_ticks(10, 2'd1, "R6 rerun");
    d_tick = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R6 ten after dominant still sync");
    d_tick = 1'b1;
    cyc(1'b1, 2'd2, 1'b0, "R6 eleven after dominant -> normal");
    d_tick = 1'b0;
    // R8: sleep request with a transmit buffer pending
    d_slp = 1'b1; d_txe = 1'b0;
    cyc(1'b1, 2'd2, 1'b0, "R8 tx pending no sleep");
    cyc(1'b1, 2'd2, 1'b0, "R8 tx pending no sleep hold");
    d_txe = 1'b1; d_rx = 1'b1;
    cyc(1'b1, 2'd2, 1'b0, "R8 receiving no sleep");
    d_rx = 1'b0;
    cyc(1'b1, 2'd3, 1'b0, "R8 idle -> sleep, ack");
    cyc(1'b1, 2'd3, 1'b0, "R8 stays asleep");
    // R9: wake by request clear
    d_slp = 1'b0;
    cyc(1'b1, 2'd2, 1'b0, "R9 request cleared wakes");
    d_slp = 1'b1;
    cyc(1'b1, 2'd3, 1'b0, "R8 sleep again");
    // R9: wake by dominant sample, request still set
    d_tick = 1'b1; d_bit = 1'b0;
    cyc(1'b1, 2'd2, 1'b0, "R9 dominant wakes");
    d_tick = 1'b0; d_bit = 1'b1;
    cyc(1'b1, 2'd3, 1'b0, "R8 re-sleep with request held");
    // R1: soft reset overrides sleep
    d_srst = 1'b1;
    cyc(1'b1, 2'd0, 1'b1, "R1 srst from sleep");
    d_slp = 1'b0; d_boff = 1'b1;
    cyc(1'b1, 2'd0, 1'b0, "R3 held in srst");
    // R7: bus-off recovery, 128 runs, dominant mid-way
    d_srst = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R7 enter sync bus-off");
    rec_ticks(11, 2'd1, "R7 first run");
    d_tick = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R7 one run not enough");
    rec_ticks(44, 2'd1, "R7 runs");
    rec_ticks(5, 2'd1, "R7 partial");
    d_bit = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R7 dominant in bus-off sync");
    rec_ticks(123 * 11 - 1, 2'd1, "R7 remaining");
    d_tick = 1'b0;
    cyc(1'b1, 2'd1, 1'b0, "R7 one bit short");
    d_tick = 1'b1;
    cyc(1'b1, 2'd2, 1'b0, "R7 128th run -> normal");
    d_tick = 1'b0;
    cyc(1'b1, 2'd2, 1'b0, "R7 stays normal");
    wait (q.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule